// File: doc/BRIEF.md
# Bit-Sliced Lookup-Table FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. It keeps the newest N unsigned samples in a single flat shift register. From that register it builds one transposed address for each sample bit position: for bit b, address bit k is bit b of the sample that entered k acceptances ago.

Each transposed address indexes a table of precomputed coefficient sums. The table for one bit position is split into several small sub-tables. Each sub-table covers a group of taps, and the outputs of the sub-tables are added. The per-bit sums are then weighted by their bit position and added together. The whole inner product is formed in one clock and registered at the edge that accepts the sample.

The coefficients are an elaboration-time parameter, so the table contents are fixed when the design is built. A producer asserts the sample strobe once per sample. A consumer takes the result in the cycle after that edge, when the result strobe is high.

Top module: `dafir_fir`

## Requirements
- R1: While `rst_n` is low and after its release, before any sample is accepted, `out_vld` is 0 and `out_res` is 0. The stored sample window is all zeros.
- R2: A sample is accepted at a rising edge of `clk` when `in_vld` is 1. It becomes the newest of the NTAPS window entries (16 by default), and the oldest entry is dropped.
- R3: `out_vld` is 1 in the cycle after each accepting edge and 0 after every edge where `in_vld` was 0.
- R4: After an accepting edge, `out_res` equals the exact sum over k = 0..NTAPS-1 of C[k]·x[k]. Here x[0] is the sample just accepted, x[k] is the sample accepted k acceptances earlier, and C[k] is the unsigned value in bits k·COEF_W +: COEF_W of the `COEFS` parameter.
- R5: An edge with `in_vld` at 0 leaves both the window and `out_res` unchanged.
- R6: Full-scale samples (all ones, 4095 for 12 bits) give (2^SMP_W − 1)·ΣC without overflow. The result width is COEF_W + SMP_W + log2(NTAPS), which is 26 bits by default.
- R7: A single sample of value 1 followed by zeros produces C[0], C[1], …, C[NTAPS−1] on successive results, then 0.
- R8: A single sample with only its most significant bit set (2048 for 12 bits) produces C[k]·2^(SMP_W−1) on the k-th following result. This tests the largest bit-slice weight.

Each bit slice uses sub-tables of SUB_W address bits (4 by default). Sub-table j takes taps j·SUB_W to j·SUB_W+SUB_W−1, with sub-address bit m standing for tap j·SUB_W+m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; must be released synchronously to `clk` |
| in_vld | input | 1 | Sample strobe; the sample is taken at the rising edge where this is 1 |
| in_smp | input | SMP_W (12) | Unsigned input sample |
| out_vld | output | 1 | High in the cycle after an accepting edge |
| out_res | output | RES_W (26) | Registered inner product of the window with the coefficients |

## Verification
Each result is due in the cycle right after the edge that accepts its sample. An idle edge must leave the result as it was and drop the strobe in the same next cycle. The bench drives inputs on the falling edge and samples 1 ns after each rising edge. At that point a behavioural window model has already applied the same edge, so the strobe and the result are compared on every clock with no extra latency. The stimulus includes impulses of value 1 and of the top bit, runs of full-scale samples, idle gaps and a pseudo-random stream with irregular strobes. Together these cover tap ordering, slice weighting, overflow headroom and hold behaviour.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  localparam int DEF_SMP_W  = 12;
  localparam int DEF_NTAPS  = 16;
  localparam int DEF_COEF_W = 10;
  localparam int DEF_SUB_W  = 4;

  // Default taps, listed from tap 15 down to tap 0.
  localparam logic [DEF_NTAPS*DEF_COEF_W-1:0] DEF_COEFS = {
    10'd3,   10'd9,   10'd20,  10'd38,
    10'd62,  10'd90,  10'd115, 10'd130,
    10'd130, 10'd115, 10'd90,  10'd62,
    10'd38,  10'd20,  10'd9,   10'd3
  };

endpackage

// File: rtl/dafir_window.sv
module dafir_window #(
  parameter int SMP_W = 12,
  parameter int NTAPS = 16,
  localparam int WIN_W = SMP_W * NTAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [SMP_W-1:0] smp_in,
  output logic [WIN_W-1:0] win_nxt
);

  logic [WIN_W-1:0] win_q;

  // Sample k (0 = newest) lives at bits k*SMP_W +: SMP_W.
  always_comb begin
    win_nxt = win_q;
    if (shift_en) begin
      win_nxt = {win_q[WIN_W-SMP_W-1:0], smp_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_nxt;
    end
  end

endmodule

// File: rtl/dafir_subtab.sv
module dafir_subtab #(
  parameter int ADDR_W = 4,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 14,
  parameter logic [ADDR_W*COEF_W-1:0] COEFS = '0,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  data
);

  // Entry a is the sum of the coefficients whose address bit is set.
  function automatic logic [OUT_W-1:0] entry_f(input int unsigned a);
    logic [OUT_W-1:0] acc;
    acc = '0;
    for (int m = 0; m < ADDR_W; m++) begin
      if (a[m]) begin
        acc = acc + OUT_W'(COEFS[m*COEF_W +: COEF_W]);
      end
    end
    return acc;
  endfunction

  logic [OUT_W-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign rom[e] = entry_f(e);
  end

  assign data = rom[addr];

endmodule

// File: rtl/dafir_slice.sv
module dafir_slice #(
  parameter int NTAPS   = 16,
  parameter int COEF_W  = 10,
  parameter int SUB_W   = 4,
  parameter int SLICE_W = 14,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
  localparam int NSUB = NTAPS / SUB_W
) (
  input  logic [NTAPS-1:0]   addr,
  output logic [SLICE_W-1:0] sum
);

  logic [SLICE_W-1:0] part [NSUB];

  for (genvar j = 0; j < NSUB; j++) begin : g_sub
    dafir_subtab #(
      .ADDR_W (SUB_W),
      .COEF_W (COEF_W),
      .OUT_W  (SLICE_W),
      .COEFS  (COEFS[j*SUB_W*COEF_W +: SUB_W*COEF_W])
    ) u_tab (
      .addr (addr[j*SUB_W +: SUB_W]),
      .data (part[j])
    );
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < NSUB; j++) begin
      sum = sum + part[j];
    end
  end

endmodule

// File: rtl/dafir_fir.sv
module dafir_fir
  import dafir_pkg::*;
#(
  parameter int SMP_W  = DEF_SMP_W,
  parameter int NTAPS  = DEF_NTAPS,
  parameter int COEF_W = DEF_COEF_W,
  parameter int SUB_W  = DEF_SUB_W,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = DEF_COEFS,
  localparam int RES_W = COEF_W + SMP_W + $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [SMP_W-1:0] in_smp,
  output logic             out_vld,
  output logic [RES_W-1:0] out_res
);

  localparam int WIN_W   = SMP_W * NTAPS;
  localparam int SLICE_W = COEF_W + $clog2(NTAPS);

  logic [WIN_W-1:0]   win_nxt;
  logic [NTAPS-1:0]   slice_addr [SMP_W];
  logic [SLICE_W-1:0] slice_sum  [SMP_W];
  logic [RES_W-1:0]   dot_sum;
  logic [RES_W-1:0]   res_nxt, res_q;
  logic               vld_nxt, vld_q;

  dafir_window #(
    .SMP_W (SMP_W),
    .NTAPS (NTAPS)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_vld),
    .smp_in   (in_smp),
    .win_nxt  (win_nxt)
  );

  // Transpose: address of slice b gathers bit b of every stored sample.
  for (genvar b = 0; b < SMP_W; b++) begin : g_bit
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      assign slice_addr[b][k] = win_nxt[k*SMP_W + b];
    end

    dafir_slice #(
      .NTAPS   (NTAPS),
      .COEF_W  (COEF_W),
      .SUB_W   (SUB_W),
      .SLICE_W (SLICE_W),
      .COEFS   (COEFS)
    ) u_slice (
      .addr (slice_addr[b]),
      .sum  (slice_sum[b])
    );
  end

  // Weight each slice by its bit position and add.
  always_comb begin
    dot_sum = '0;
    for (int b = 0; b < SMP_W; b++) begin
      dot_sum = dot_sum + (RES_W'(slice_sum[b]) << b);
    end
  end

  always_comb begin
    vld_nxt = in_vld;
    res_nxt = res_q;
    if (in_vld) begin
      res_nxt = dot_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      res_q <= res_nxt;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
  parameter int SMP_W  = 12,
  parameter int NTAPS  = 16,
  parameter int COEF_W = 10,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
  parameter int RES_W  = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [SMP_W-1:0] in_smp,
  input logic             out_vld,
  input logic [RES_W-1:0] out_res
);

  localparam longint FULL = (longint'(1) << SMP_W) - 1;

  function automatic longint csum_f();
    longint s;
    s = 0;
    for (int k = 0; k < NTAPS; k++) begin
      s = s + longint'(COEFS[k*COEF_W +: COEF_W]);
    end
    return s;
  endfunction

  localparam longint MAXV = csum_f() * FULL;
  localparam longint C0   = longint'(COEFS[COEF_W-1:0]);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R3

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(out_res) <= MAXV); // R6

  AST_NEWEST_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (in_smp == {SMP_W{1'b1}})) |=> (longint'(out_res) >= C0 * FULL)); // R4

endmodule

bind dafir_fir dafir_chk #(
  .SMP_W  (SMP_W),
  .NTAPS  (NTAPS),
  .COEF_W (COEF_W),
  .COEFS  (COEFS),
  .RES_W  (RES_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_smp  (in_smp),
  .out_vld (out_vld),
  .out_res (out_res)
);

// File: tb/sim_dafir_fir.sv
`timescale 1ns/1ps
module sim_dafir_fir;

  localparam int SMP_W  = 12;
  localparam int NTAPS  = 16;
  localparam int COEF_W = 10;
  localparam int SUB_W  = 4;
  localparam int RES_W  = COEF_W + SMP_W + $clog2(NTAPS);
  localparam int CF [NTAPS] = '{1023, 7, 300, 64, 512, 1, 255, 999,
                                128, 33, 700, 2, 450, 81, 640, 19};

  function automatic logic [NTAPS*COEF_W-1:0] pack_f();
    logic [NTAPS*COEF_W-1:0] v;
    v = '0;
    for (int k = 0; k < NTAPS; k++) v[k*COEF_W +: COEF_W] = COEF_W'(CF[k]);
    return v;
  endfunction

  localparam logic [NTAPS*COEF_W-1:0] CV = pack_f();

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [SMP_W-1:0] in_smp = '0;
  logic             out_vld;
  logic [RES_W-1:0] out_res;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  longint win [NTAPS];
  longint exp_res = 0;
  bit     exp_vld = 1'b0;

  always #10 clk = ~clk;

  dafir_fir #(
    .SMP_W (SMP_W), .NTAPS (NTAPS), .COEF_W (COEF_W), .SUB_W (SUB_W), .COEFS (CV)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_smp (in_smp),
    .out_vld (out_vld), .out_res (out_res)
  );

  task automatic compare(input string tag);
    checks++;
    if (out_vld !== exp_vld) begin
      errors++;
      $display("FAIL %s R3 out_vld got %0b exp %0b", tag, out_vld, exp_vld);
    end
    checks++;
    if (out_res !== RES_W'(exp_res)) begin
      errors++;
      $display("FAIL %s out_res got %0d exp %0d", tag, out_res, exp_res);
    end
  endtask

  task automatic step(input bit v, input int d, input string tag);
    @(negedge clk);
    in_vld = v;
    in_smp = SMP_W'(d);
    @(posedge clk);
    #1;
    if (v) begin
      for (int k = NTAPS - 1; k > 0; k--) win[k] = win[k-1];
      win[0] = longint'(d);
      exp_res = 0;
      for (int k = 0; k < NTAPS; k++) exp_res += longint'(CF[k]) * win[k];
    end
    exp_vld = v;
    compare(tag);
  endtask

  initial begin
    for (int k = 0; k < NTAPS; k++) win[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    compare("R1 after release");
    step(1'b0, 0, "R1 idle after reset");

    // R7 / R2: impulse of 1 walks through the taps and then drops out
    step(1'b1, 1, "R7 impulse");
    for (int i = 0; i < NTAPS + 2; i++) step(1'b1, 0, "R7 R2 impulse tail");

    // R8: top-bit impulse
    step(1'b1, 1 << (SMP_W - 1), "R8 msb impulse");
    for (int i = 0; i < NTAPS + 1; i++) step(1'b1, 0, "R8 msb tail");

    // R6: full scale
    for (int i = 0; i < NTAPS + 4; i++) step(1'b1, (1 << SMP_W) - 1, "R6 full scale");

    // R5: idle gaps hold the result and the window
    for (int i = 0; i < 5; i++) step(1'b0, 123 * i, "R5 idle hold");
    step(1'b1, 7, "R5 R2 resume after gap");
    for (int i = 0; i < 3; i++) step(1'b0, 4000, "R5 idle hold 2");
    step(1'b1, 0, "R5 R4 resume");

    // R4 / R2: pseudo-random samples with irregular strobes
    begin
      int unsigned s;
      s = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
        s = s * 32'd1103515245 + 32'd12345;
        step((s[27:25] != 3'd0), int'(s[SMP_W+7:8]), "R4 R2 random");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule